// File: doc/BRIEF.md
# Masked Dual Alarm Comparator

This block watches the running calendar time and reports when either of two programmed alarm settings matches it. The live time and each alarm setting arrive as six BCD bytes: seconds, minutes, hours, date, month and weekday. In every alarm byte, bit 7 is a per-field enable. Only the enabled fields are compared, so one alarm can fire once a minute, once a day or once a year. The compare runs once per one-second tick. A match raises a sticky per-alarm flag. If that alarm's interrupt enable is set, the match also starts an active-low interrupt pulse of fixed length.

A mode input chooses between two behaviours. In single-event mode, an alarm interrupts only on the match that sets its flag. In recurring mode, it interrupts on every matching tick. Flags are cleared by a status read, which the surrounding logic reports with two strobes. The first strobe marks the start of the read. The second marks the point where the read data has been delivered. Only the flags that were already set at the start strobe are cleared. An alarm that fires during the read stays flagged for the next read. Register storage and the bus protocol live outside this block.

Top module: `alarm_match_unit`

## Requirements
- R1: Time and alarm vectors hold six bytes: seconds [7:0], minutes [15:8], hours [23:16], date [31:24], month [39:32], weekday [47:40]. An alarm field takes part in the compare only when its bit 7 is 1. When it does, its bits [6:0] must equal the live byte's bits [6:0]. An alarm matches when it has at least one enabled field and every enabled field is equal.
- R2: An alarm whose six enable bits are all 0 never matches, whatever its value bits are.
- R3: In the hours compare, bit 7 of the live hour byte (the 12/24-hour select) is ignored. The alarm hour uses the 0–23 encoding in bits [5:0].
- R4: The compare takes effect only in a cycle where `tick_i` is 1. A match sets that alarm's `flags_o` bit after that clock edge, whether or not its interrupt enable is set. With no tick, nothing changes.
- R5: When a matching alarm has its `irq_en_i` bit at 1, `irq_n_o` goes low at the edge that samples the tick and stays low for exactly `PULSE_CYCLES` cycles. A match of an alarm whose enable is 0 causes no pulse.
- R6: With `repeat_i` at 0, a match produces a pulse only if that alarm's flag was 0 before the tick. With `repeat_i` at 1, every matching tick produces a pulse.
- R7: `rd_start_i` captures which flags are set at that moment. `rd_clear_i` clears only the captured flags. A flag that sets after the start strobe stays set. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R8: A match that occurs while a pulse is active neither extends nor restarts that pulse.
- R9: After reset, `flags_o` is 0 and `irq_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe, once per second |
| time_i | input | 48 | Live BCD time, six bytes as in R1 |
| alarms_i | input | NUM_ALARMS*48 | Alarm settings; alarm k occupies bits [48k+47:48k] |
| irq_en_i | input | NUM_ALARMS | Per-alarm interrupt enable |
| repeat_i | input | 1 | 0 = single event, 1 = recurring |
| rd_start_i | input | 1 | Status read has begun |
| rd_clear_i | input | 1 | Status read data delivered; clear captured flags |
| flags_o | output | NUM_ALARMS | Sticky per-alarm match flags |
| irq_n_o | output | 1 | Active-low interrupt pulse |

## Verification
The properties assume three things about the inputs. `tick_i` is a single-cycle strobe. `rd_start_i` comes before the matching `rd_clear_i` in a separate cycle. The time and alarm bytes stay steady around the tick. The bench meets all three. It drives every input at the falling clock edge and raises each strobe for exactly one cycle. It changes the time and alarm vectors only while no tick is pending. It issues the start and clear strobes in sequence, and lets a tick coincide with one of them only in the deliberate set-versus-clear case.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 6;
    localparam int TIME_W     = FIELD_W * NUM_FIELDS;
    localparam int EN_BIT     = FIELD_W - 1;
    localparam int HOUR_IDX   = 2;
endpackage

// File: rtl/alm_match.sv
module alm_match
    import alm_pkg::*;
(
    input  logic [TIME_W-1:0] now_i,
    input  logic [TIME_W-1:0] alarm_i,
    output logic              hit_o,
    output logic              armed_o
);
    logic [NUM_FIELDS-1:0] en_v;
    logic [NUM_FIELDS-1:0] ok_v;
    logic [NUM_FIELDS-1:0] unused_live_msb;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam int BASE = f * FIELD_W;
        logic [EN_BIT-1:0] want;
        logic [EN_BIT-1:0] have;
        assign want = alarm_i[BASE +: EN_BIT];
        // the live hour MSB selects 12/24-hour display and is never compared
        assign have = now_i[BASE +: EN_BIT];
        assign en_v[f] = alarm_i[BASE + EN_BIT];
        assign ok_v[f] = !en_v[f] || (want == have);
        assign unused_live_msb[f] = now_i[BASE + EN_BIT];
    end

    logic unused_ok;
    assign unused_ok = ^unused_live_msb;

    assign armed_o = |en_v;
    assign hit_o   = armed_o && (&ok_v);
endmodule

// File: rtl/alm_irq_timer.sv
module alm_irq_timer #(
    parameter int PULSE_CYCLES = 400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic irq_n_o
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else if (fire_i) begin
            cnt_d = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign irq_n_o = (cnt_q == '0);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alm_pkg::*;
#(
    parameter int NUM_ALARMS   = 2,
    parameter int PULSE_CYCLES = 400000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_i,
    input  logic [TIME_W-1:0]            time_i,
    input  logic [NUM_ALARMS*TIME_W-1:0] alarms_i,
    input  logic [NUM_ALARMS-1:0]        irq_en_i,
    input  logic                         repeat_i,
    input  logic                         rd_start_i,
    input  logic                         rd_clear_i,
    output logic [NUM_ALARMS-1:0]        flags_o,
    output logic                         irq_n_o
);
    typedef struct packed {
        logic [NUM_ALARMS-1:0] flags;
        logic [NUM_ALARMS-1:0] snap;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_ALARMS-1:0] hit_v;
    logic [NUM_ALARMS-1:0] armed_v;
    logic [NUM_ALARMS-1:0] set_v;
    logic [NUM_ALARMS-1:0] clr_v;
    logic [NUM_ALARMS-1:0] gate_v;
    logic                  fire;

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        alm_match u_match (
            .now_i   (time_i),
            .alarm_i (alarms_i[a*TIME_W +: TIME_W]),
            .hit_o   (hit_v[a]),
            .armed_o (armed_v[a])
        );
    end

    always_comb begin
        st_d   = st_q;
        set_v  = hit_v & {NUM_ALARMS{tick_i}};
        clr_v  = rd_clear_i ? st_q.snap : '0;
        if (rd_start_i) st_d.snap = st_q.flags;
        if (rd_clear_i) st_d.snap = '0;
        // a set in the same cycle as a clear wins
        st_d.flags = (st_q.flags & ~clr_v) | set_v;
        gate_v = repeat_i ? {NUM_ALARMS{1'b1}} : ~st_q.flags;
        fire   = |(set_v & irq_en_i & gate_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    alm_irq_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .irq_n_o (irq_n_o)
    );

    assign flags_o = st_q.flags;
endmodule

// File: rtl/alm_checker.sv
module alm_checker #(
    parameter int NUM_ALARMS   = 2,
    parameter int PULSE_CYCLES = 400000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_i,
    input logic                  rd_clear_i,
    input logic [NUM_ALARMS-1:0] armed_v,
    input logic [NUM_ALARMS-1:0] flags_o,
    input logic                  irq_n_o
);
    int low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_run <= 0;
        else if (!irq_n_o) low_run <= low_run + 1;
        else               low_run <= 0;
    end

    // R5: a pulse can only begin at a tick
    a_r5_pulse_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> $past(tick_i));

    // R8: every pulse lasts exactly the configured length, never longer
    a_r8_exact_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n_o) |-> (low_run == PULSE_CYCLES));

    a_r8_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= PULSE_CYCLES);

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_chk
        // R4: a flag rises only at a tick
        a_r4_flag_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_o[a]) |-> $past(tick_i));

        // R7: a flag falls only at the clear strobe
        a_r7_fall_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags_o[a]) |-> $past(rd_clear_i));

        // R2: an alarm without enables cannot set its flag
        a_r2_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!armed_v[a] && !flags_o[a]) |=> !flags_o[a]);
    end
endmodule

bind alarm_match_unit alm_checker #(
    .NUM_ALARMS   (NUM_ALARMS),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .rd_clear_i (rd_clear_i),
    .armed_v    (armed_v),
    .flags_o    (flags_o),
    .irq_n_o    (irq_n_o)
);

// File: tb/sim_alarm_match_unit.sv
module sim_alarm_match_unit;
    localparam int PW = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        tick = 0;
    logic [47:0] tnow = '0;
    logic [47:0] a0 = '0, a1 = '0;
    logic [1:0]  irq_en = '0;
    logic        rep = 0;
    logic        rd_s = 0, rd_c = 0;
    logic [1:0]  flags;
    logic        irq_n;

    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    alarm_match_unit #(.NUM_ALARMS(2), .PULSE_CYCLES(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .time_i(tnow),
        .alarms_i({a1, a0}), .irq_en_i(irq_en), .repeat_i(rep),
        .rd_start_i(rd_s), .rd_clear_i(rd_c), .flags_o(flags), .irq_n_o(irq_n)
    );

    typedef struct packed {
        logic [47:0] t;
        logic [47:0] v0;
        logic [47:0] v1;
        logic [1:0]  en;
        logic        rp;
        logic [1:0]  ef;
        logic        elow;
    } vec_t;

    // live time: wday 2, month 03, date 21, hour 08 with 24h select set, min 15, sec 30
    localparam logic [47:0] T0 = 48'h02_03_21_88_15_30;

    localparam vec_t VECS [6] = '{
        // R1 seconds only; R2 alarm1 carries matching values without enables
        '{T0, 48'h00_00_00_00_00_B0, 48'h02_03_21_08_15_30, 2'b11, 1'b0, 2'b01, 1'b1},
        // R3 hour compare ignores the live 24h select bit
        '{T0, 48'h00_00_00_00_00_B1, 48'h00_00_00_88_95_00, 2'b11, 1'b0, 2'b10, 1'b1},
        // R4/R5 flag without interrupt enable gives no pulse
        '{T0, 48'h82_83_A1_00_00_00, 48'h00_00_00_00_00_00, 2'b10, 1'b0, 2'b01, 1'b0},
        // R1 mismatching enabled fields
        '{T0, 48'h00_00_00_89_00_00, 48'h00_84_00_00_00_00, 2'b11, 1'b0, 2'b00, 1'b0},
        // R1 one enabled mismatch blocks; disabled mismatch ignored
        '{T0, 48'h00_00_A2_00_00_B0, 48'h00_00_00_00_59_B0, 2'b11, 1'b0, 2'b10, 1'b1},
        // R6 recurring mode, both match
        '{T0, 48'h00_00_00_00_00_B0, 48'h00_00_00_00_95_00, 2'b01, 1'b1, 2'b11, 1'b1}
    };

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1;
        @(negedge clk) tick = 0;
    endtask

    task automatic do_read();
        @(negedge clk) rd_s = 1;
        @(negedge clk) rd_s = 0; rd_c = 1;
        @(negedge clk) rd_c = 0;
    endtask

    task automatic settle();
        repeat (PW + 2) @(negedge clk);
    endtask

    initial begin : main
        int lowc;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 flags", 64'(flags), 64'd0);
        chk("R9 irq", 64'(irq_n), 64'd1);
        rst_n = 1;
        @(negedge clk);

        foreach (VECS[i]) begin
            do_read();
            settle();
            tnow = VECS[i].t; a0 = VECS[i].v0; a1 = VECS[i].v1;
            irq_en = VECS[i].en; rep = VECS[i].rp;
            do_tick();
            chk($sformatf("R1 vec%0d flags", i), 64'(flags), 64'(VECS[i].ef));
            chk($sformatf("R5 vec%0d irq", i), 64'(irq_n), 64'(!VECS[i].elow));
        end

        // R4: matching inputs without a tick do nothing
        do_read(); settle();
        tnow = T0; a0 = 48'h00_00_00_00_00_B0; a1 = '0; irq_en = 2'b01; rep = 0;
        repeat (3) @(negedge clk);
        chk("R4 no tick flags", 64'(flags), 64'd0);
        chk("R4 no tick irq", 64'(irq_n), 64'd1);

        // R5: pulse length
        do_tick();
        lowc = 0;
        for (int k = 0; k < 40; k++) begin
            if (!irq_n) lowc++;
            @(negedge clk);
        end
        chk("R5 width", 64'(lowc), 64'(PW));

        // R6 single event: flag already set, no second pulse
        do_tick();
        chk("R6 single no pulse", 64'(irq_n), 64'd1);
        chk("R6 single flag", 64'(flags), 64'd1);
        settle();
        rep = 1;
        do_tick();
        chk("R6 recurring pulse", 64'(irq_n), 64'd0);

        // R8: new match mid-pulse does not stretch it (first low already seen)
        lowc = 0;
        for (int k = 0; k < 40; k++) begin
            if (!irq_n) lowc++;
            if (k == 2) tick = 1;
            if (k == 3) tick = 0;
            @(negedge clk);
        end
        chk("R8 no extend", 64'(lowc), 64'(PW));

        // R7: flag set during read survives
        rep = 0;
        @(negedge clk) rd_s = 1;
        @(negedge clk) rd_s = 0;
        a0 = 48'h00_00_00_00_00_B1; a1 = 48'h00_00_00_00_95_00; irq_en = 2'b00;
        do_tick();
        chk("R7 both set", 64'(flags), 64'd3);
        @(negedge clk) rd_c = 1;
        @(negedge clk) rd_c = 0;
        chk("R7 keep late flag", 64'(flags), 64'd2);

        // R7: set and clear in the same cycle, set wins
        @(negedge clk) rd_s = 1;
        @(negedge clk) rd_s = 0; rd_c = 1; tick = 1;
        @(negedge clk) rd_c = 0; tick = 0;
        chk("R7 set beats clear", 64'(flags), 64'd2);
        a1 = '0;
        do_read();
        chk("R7 plain clear", 64'(flags), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule